// File: doc/BRIEF.md
# DSP Slice Self-Test Sequencer

This block orchestrates a built-in self-test of a multiply-add DSP slice. A small configuration word is loaded serially, one bit per clock, into a shadow register through a scan-style shift port. It is copied into the active configuration by an update strobe while the sequencer is idle. The word selects one of two operating-code schedules and the multiplier pattern variant. It can also invert the slice's other control inputs, or hold the sequencer in its reset state.

Once started, the sequencer runs for 1024 clock cycles, split into four groups of 256. In each group it presents the operating code that steers the slice's operand multiplexers. It alternates two load strobes so that each adder vector takes two cycles: the X-path operand goes in the first cycle and the Y and Z operands in the second. It also drives the slice's other control inputs. In the first half of the run these hold a fixed value. In the second half a 16-bit LFSR supplies pseudo-random values. The pattern generators, the slice and the result readout sit outside the block and only receive these selects and strobes.

Top module: `dsp_bist_seq`

## Requirements
- R1: After reset, busy, done, group, opcode, ctrl, x_load and yz_load are all zero, and the shadow and active configurations are cleared.
- R2: With shift_en high, shift_in is captured each clock into a 4-bit shadow register, LSB first: the fourth bit shifted ends in bit 3. Bit meanings: [1:0] test mode, [2] control inversion, [3] hold. An update while idle copies the shadow into the active configuration. If bit 3 is 0, busy rises on the following clock edge.
- R3: A run lasts 1024 cycles. The group output equals the cycle index within the run divided by 256 (0 to 3).
- R4: While busy, opcode comes from a per-group table. With mode bit 1 at 0 the groups 0..3 give 0x05, 0x25, 0x35, 0x15. With mode bit 1 at 1 they give 0x0F, 0x2F, 0x3F, 0x1F. alg_sel always shows active mode bit 0.
- R5: While busy, x_load is high on even cycles of the run (starting with the first) and yz_load on odd cycles, never both.
- R6: In groups 0 and 1, ctrl equals 0x00, XORed with all ones when the inversion bit is set.
- R7: In groups 2 and 3, ctrl is the low 8 bits of an LFSR, inverted if the inversion bit is set. The LFSR is reseeded to 0xACE1 at each update and holds that value in the first cycle of group 2. After each cycle of groups 2 and 3 it shifts left by one, taking bit 15 ^ bit 13 ^ bit 12 ^ bit 10 into bit 0 (x^16+x^14+x^13+x^11+1).
- R8: After the 1024th run cycle busy falls and done rises. Done stays high until reset or the next update.
- R9: An update while busy is ignored. Shifting while busy changes only the shadow, which a later idle update loads.
- R10: An idle update with bit 3 set loads the configuration, clears done and starts no run.
- R11: While not busy, opcode, ctrl, x_load and yz_load are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shift_en | input | 1 | Enables serial capture into the shadow register |
| shift_in | input | 1 | Serial configuration bit, LSB first |
| update | input | 1 | Copies the shadow into the active configuration when idle |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run completed |
| group | output | 2 | Current group index |
| opcode | output | 7 | Operating code for the slice's operand multiplexers |
| x_load | output | 1 | Apply X-path adder operand |
| yz_load | output | 1 | Apply Y and Z adder operands |
| alg_sel | output | 1 | Multiplier pattern variant select |
| ctrl | output | 8 | Remaining slice control inputs |

## Verification
The assertions rely on reset being asserted from time zero and on update being a single-cycle strobe. They also expect shift_en to be used only to build a word, not held across a run boundary in a way that matters to the outputs. The stimulus drives all inputs away from the clock edge. It pulses update for exactly one cycle, including the pulse injected mid-run, and applies random configuration words alongside directed ones for hold, inversion and mid-run reset.

// File: rtl/dsp_bist_pkg.sv
package dsp_bist_pkg;

   typedef struct packed {
      logic       hold;
      logic       inv;
      logic [1:0] mode;
   } bist_cfg_t;

   localparam int CFG_W = $bits(bist_cfg_t);

endpackage

// File: rtl/bist_cfg_reg.sv
module bist_cfg_reg
   import dsp_bist_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       shift_en,
   input  logic       shift_in,
   input  logic       update,
   input  logic       idle,
   output logic       load,
   output logic       load_hold,
   output logic [1:0] act_mode,
   output logic       act_inv
);

   bist_cfg_t shadow_q;

   assign load      = update & idle;
   assign load_hold = shadow_q.hold;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow_q <= '0;
      end else if (shift_en) begin
         shadow_q <= bist_cfg_t'({shift_in, shadow_q[CFG_W-1:1]});
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_mode <= '0;
         act_inv  <= 1'b0;
      end else if (load) begin
         act_mode <= shadow_q.mode;
         act_inv  <= shadow_q.inv;
      end
   end

endmodule

// File: rtl/bist_group_fsm.sv
module bist_group_fsm #(
   parameter int GROUP_LEN = 256,
   parameter int N_GROUPS  = 4,
   localparam int TOTAL    = GROUP_LEN * N_GROUPS,
   localparam int CNT_W    = $clog2(TOTAL),
   localparam int GRP_W    = $clog2(N_GROUPS)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             hold,
   output logic             busy,
   output logic             done,
   output logic [GRP_W-1:0] group,
   output logic             phase
);

   logic [CNT_W-1:0] cnt_q;
   logic             last;

   assign last  = (cnt_q == CNT_W'(TOTAL - 1));
   assign group = cnt_q[CNT_W-1 -: GRP_W];
   assign phase = cnt_q[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         done  <= 1'b0;
         cnt_q <= '0;
      end else if (load) begin
         busy  <= ~hold;
         done  <= 1'b0;
         cnt_q <= '0;
      end else if (busy) begin
         cnt_q <= cnt_q + 1'b1;
         if (last) begin
            busy <= 1'b0;
            done <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/bist_lfsr.sv
module bist_lfsr #(
   parameter int              W    = 16,
   parameter logic [W-1:0]    TAPS = 16'hB400,
   parameter logic [W-1:0]    SEED = 16'hACE1
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         reseed,
   input  logic         step,
   output logic [W-1:0] state
);

   logic fb;
   assign fb = ^(state & TAPS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= SEED;
      end else if (reseed) begin
         state <= SEED;
      end else if (step) begin
         state <= {state[W-2:0], fb};
      end
   end

endmodule

// File: rtl/dsp_bist_seq.sv
module dsp_bist_seq
   import dsp_bist_pkg::*;
#(
   parameter int GROUP_LEN = 256,
   parameter int N_GROUPS  = 4,
   parameter int OPC_W     = 7,
   parameter int CTRL_W    = 8,
   parameter int LFSR_W    = 16,
   parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
   parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1,
   parameter logic [CTRL_W-1:0] CTRL_FIXED = '0,
   parameter logic [N_GROUPS*OPC_W-1:0] OPC_TAB_A = {7'h15, 7'h35, 7'h25, 7'h05},
   parameter logic [N_GROUPS*OPC_W-1:0] OPC_TAB_B = {7'h1F, 7'h3F, 7'h2F, 7'h0F}
)(
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        shift_en,
   input  logic                        shift_in,
   input  logic                        update,
   output logic                        busy,
   output logic                        done,
   output logic [$clog2(N_GROUPS)-1:0] group,
   output logic [OPC_W-1:0]            opcode,
   output logic                        x_load,
   output logic                        yz_load,
   output logic                        alg_sel,
   output logic [CTRL_W-1:0]           ctrl
);

   localparam int GRP_W = $clog2(N_GROUPS);

   if (GROUP_LEN < 2 || (GROUP_LEN & (GROUP_LEN - 1)) != 0) begin : g_bad_len
      $error("GROUP_LEN must be a power of two of at least 2");
   end
   if (N_GROUPS < 2 || (N_GROUPS & (N_GROUPS - 1)) != 0) begin : g_bad_groups
      $error("N_GROUPS must be a power of two of at least 2");
   end
   if (LFSR_SEED == '0) begin : g_bad_seed
      $error("LFSR_SEED must be nonzero");
   end

   logic             load, load_hold, act_inv, phase, rnd_half;
   logic [1:0]       act_mode;
   logic [LFSR_W-1:0] lfsr_q;
   logic [CTRL_W-1:0] rnd_ctrl, ctrl_src;
   logic [OPC_W-1:0]  tab_a [N_GROUPS];
   logic [OPC_W-1:0]  tab_b [N_GROUPS];

   bist_cfg_reg i_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .shift_en  (shift_en),
      .shift_in  (shift_in),
      .update    (update),
      .idle      (~busy),
      .load      (load),
      .load_hold (load_hold),
      .act_mode  (act_mode),
      .act_inv   (act_inv)
   );

   bist_group_fsm #(.GROUP_LEN(GROUP_LEN), .N_GROUPS(N_GROUPS)) i_fsm (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load),
      .hold  (load_hold),
      .busy  (busy),
      .done  (done),
      .group (group),
      .phase (phase)
   );

   assign rnd_half = busy & group[GRP_W-1];

   bist_lfsr #(.W(LFSR_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) i_lfsr (
      .clk    (clk),
      .rst_n  (rst_n),
      .reseed (load),
      .step   (rnd_half),
      .state  (lfsr_q)
   );

   if (CTRL_W > LFSR_W) begin : g_bad_ctrl
      $error("CTRL_W may not exceed LFSR_W");
      assign rnd_ctrl = '0;
   end else if (CTRL_W == LFSR_W) begin : g_rnd_full
      assign rnd_ctrl = lfsr_q;
   end else begin : g_rnd_part
      assign rnd_ctrl = lfsr_q[CTRL_W-1:0];
   end

   for (genvar g = 0; g < N_GROUPS; g++) begin : g_tab
      assign tab_a[g] = OPC_TAB_A[g*OPC_W +: OPC_W];
      assign tab_b[g] = OPC_TAB_B[g*OPC_W +: OPC_W];
   end

   assign ctrl_src = rnd_half ? rnd_ctrl : CTRL_FIXED;

   always_comb begin
      opcode  = '0;
      ctrl    = '0;
      x_load  = 1'b0;
      yz_load = 1'b0;
      if (busy) begin
         opcode  = act_mode[1] ? tab_b[group] : tab_a[group];
         ctrl    = ctrl_src ^ {CTRL_W{act_inv}};
         x_load  = ~phase;
         yz_load = phase;
      end
   end

   assign alg_sel = act_mode[0];

endmodule

// File: rtl/bist_seq_chk.sv
module bist_seq_chk #(
   parameter int GRP_W  = 2,
   parameter int OPC_W  = 7,
   parameter int CTRL_W = 8
)(
   input logic              clk,
   input logic              rst_n,
   input logic              update,
   input logic              busy,
   input logic              done,
   input logic [GRP_W-1:0]  group,
   input logic [OPC_W-1:0]  opcode,
   input logic              x_load,
   input logic              yz_load,
   input logic [CTRL_W-1:0] ctrl
);

   a_r8_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && done));

   a_r8_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
      done && !update |=> done);

   a_r3_group_step: assert property (@(posedge clk) disable iff (!rst_n)
      busy && $past(busy) |-> (group == $past(group)) || (group == $past(group) + 1'b1));

   a_r5_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> $countones({x_load, yz_load}) == 1);

   a_r5_x_then_yz: assert property (@(posedge clk) disable iff (!rst_n)
      busy && x_load |=> !busy || yz_load);

   a_r6_fixed_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
      busy && $past(busy) && !group[GRP_W-1] && !$past(group[GRP_W-1]) |-> $stable(ctrl));

   a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (opcode == '0) && (ctrl == '0) && !x_load && !yz_load);

endmodule

bind dsp_bist_seq bist_seq_chk #(
   .GRP_W  ($clog2(N_GROUPS)),
   .OPC_W  (OPC_W),
   .CTRL_W (CTRL_W)
) i_chk (.*);

// File: tb/test_dsp_bist_seq.sv
`timescale 1ns/1ps
module test_dsp_bist_seq;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       shift_en = 1'b0;
   logic       shift_in = 1'b0;
   logic       update = 1'b0;
   logic       busy, done, x_load, yz_load, alg_sel;
   logic [1:0] group;
   logic [6:0] opcode;
   logic [7:0] ctrl;

   int n_checks = 0;
   int n_fail   = 0;
   int cycles   = 0;

   always #5 clk = ~clk;

   dsp_bist_seq i_dsp_bist_seq (
      .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .shift_in(shift_in),
      .update(update), .busy(busy), .done(done), .group(group),
      .opcode(opcode), .x_load(x_load), .yz_load(yz_load),
      .alg_sel(alg_sel), .ctrl(ctrl)
   );

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h at t=%0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [6:0] opc_exp(input bit tab_b, input int g);
      logic [6:0] r;
      case (g)
         0: r = tab_b ? 7'h0F : 7'h05;
         1: r = tab_b ? 7'h2F : 7'h25;
         2: r = tab_b ? 7'h3F : 7'h35;
         default: r = tab_b ? 7'h1F : 7'h15;
      endcase
      return r;
   endfunction

   function automatic logic [15:0] lfsr_next(input logic [15:0] v);
      return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
   endfunction

   task automatic shift_word(input logic [3:0] v);
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         shift_en = 1'b1;
         shift_in = v[i];
      end
      @(negedge clk);
      shift_en = 1'b0;
      shift_in = 1'b0;
   endtask

   task automatic pulse_update();
      @(negedge clk);
      update = 1'b1;
      @(negedge clk);
      update = 1'b0;
   endtask

   task automatic check_idle(input string req);
      chk(busy == 1'b0, req, busy, 0);
      chk(opcode == '0 && ctrl == '0 && !x_load && !yz_load, req,
          {opcode, ctrl, x_load, yz_load}, 0);
   endtask

   // Checks a full run; sits at the first run cycle on entry, leaves one cycle after the run.
   // inject: when set, shifts nxt into the shadow and pulses update mid-run (R9).
   task automatic run_check(input logic [3:0] v, input bit inject, input logic [3:0] nxt);
      logic [15:0] lf = 16'hACE1;
      logic [7:0]  inv = {8{v[2]}};
      logic [7:0]  ce;
      for (int k = 0; k < 1024; k++) begin
         chk(busy == 1'b1 && done == 1'b0, "R3 busy during run", {busy, done}, 2'b10);
         chk(group == 2'(k / 256), "R3 group index", group, k / 256);
         chk(opcode == opc_exp(v[1], k / 256), "R4 opcode table", opcode, opc_exp(v[1], k / 256));
         chk(alg_sel == v[0], "R4 alg_sel", alg_sel, v[0]);
         chk(x_load == (k % 2 == 0) && yz_load == (k % 2 == 1), "R5 adder phase",
             {x_load, yz_load}, {k % 2 == 0, k % 2 == 1});
         if (k < 512) begin
            ce = 8'h00 ^ inv;
            chk(ctrl == ce, "R6 fixed ctrl", ctrl, ce);
         end else begin
            ce = lf[7:0] ^ inv;
            chk(ctrl == ce, "R7 lfsr ctrl", ctrl, ce);
            lf = lfsr_next(lf);
         end
         if (inject && k >= 300 && k < 304) begin
            shift_en = 1'b1;
            shift_in = nxt[k - 300];
         end else begin
            shift_en = 1'b0;
            shift_in = 1'b0;
         end
         update = (inject && k == 305);
         @(negedge clk);
      end
      update = 1'b0;
      chk(busy == 1'b0 && done == 1'b1, "R8 done after run", {busy, done}, 2'b01);
      check_idle("R11 idle after run");
   endtask

   initial begin
      logic [3:0] cfg;
      void'($urandom(32'h5EED));
      repeat (3) @(negedge clk);
      chk(busy == 0 && done == 0 && group == 0, "R1 reset state", {busy, done, group}, 0);
      check_idle("R1 reset outputs");
      rst_n = 1'b1;

      // R2: plain run, table A, no inversion
      shift_word(4'b0000);
      pulse_update();
      run_check(4'b0000, 1'b0, 4'b0000);
      repeat (5) @(negedge clk);
      chk(done == 1'b1, "R8 done holds", done, 1);

      // R2 bit order, R4 table B, R6/R7 inversion
      shift_word(4'b0110);
      pulse_update();
      run_check(4'b0110, 1'b0, 4'b0000);

      // R9: update and shift during a run are ignored for that run
      shift_word(4'b0001);
      pulse_update();
      run_check(4'b0001, 1'b1, 4'b0111);
      pulse_update();
      run_check(4'b0111, 1'b0, 4'b0000);

      // R10: hold bit
      shift_word(4'b1010);
      pulse_update();
      chk(done == 1'b0, "R10 hold clears done", done, 0);
      check_idle("R10 hold starts no run");
      repeat (3) @(negedge clk);
      chk(busy == 1'b0, "R10 still idle", busy, 0);
      chk(alg_sel == 1'b0, "R10 config loaded", alg_sel, 0);

      // R1: reset mid-run
      shift_word(4'b0101);
      pulse_update();
      repeat (40) @(negedge clk);
      chk(busy == 1'b1, "R3 busy before reset", busy, 1);
      rst_n = 1'b0;
      @(negedge clk);
      chk(done == 0 && group == 0 && alg_sel == 0, "R1 reset mid-run", {done, group, alg_sel}, 0);
      check_idle("R1 idle after reset");
      rst_n = 1'b1;
      pulse_update();
      run_check(4'b0000, 1'b0, 4'b0000);

      // Random configurations
      for (int r = 0; r < 5; r++) begin
         cfg = 4'($urandom) & 4'b0111;
         shift_word(cfg);
         pulse_update();
         run_check(cfg, 1'b0, 4'b0000);
      end

      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

endmodule